// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block runs the bus cycle a bus master uses to acknowledge an interrupt and fetch its vector number. When the master asks it to acknowledge a pending level from 1 to 7, it opens a read-type cycle in the CPU address space. During that cycle the function code is all ones. The acknowledged level sits on address bits 3..1, and every other address bit is driven high. After one address-setup cycle it raises the address and data strobes. It then waits, with as many wait states as the responder needs, for one of two terminations.

A data acknowledge means the responding device supplied the vector, and the low byte of the data input is taken. A peripheral-valid response means the device asks for an autovector, and the block forms it as 0x18 plus the level. The two terminations are illegal together. If both are sampled on the same edge, the block flags a protocol error and returns the spurious vector 0x18. Completion is a one-cycle `done_o` pulse, and `vector_o` holds the result until the next completion.

Top module: `iack_seq`

## Requirements
- R1: After reset, `busy_o`, `as_o`, `ds_o`, `done_o` and `err_o` are 0, `fc_o` is 000, `addr_o` is all zeros, `vector_o` is 0 and `rw_o` is 1.
- R2: A `start_i` sampled while idle with a nonzero `level_i` makes `busy_o` 1 from the next cycle. While busy, `fc_o` is 111 and `rw_o` is 1.
- R3: While busy, `addr_o[3:1]` equals the accepted level, and every other address bit, bit 0 included, is 1. While not busy, `addr_o` is 0.
- R4: The first busy cycle is address setup with both strobes low. From the second busy cycle on, `as_o` and `ds_o` are both 1 until termination.
- R5: A start with `level_i` = 0 is ignored, and `busy_o` stays 0.
- R6: If `dtack_i` alone is sampled at a clock edge while the strobes are 1, then from the next cycle `done_o` is 1 for exactly one cycle. `vector_o` becomes `data_i[7:0]`, `err_o` is 0, and `busy_o` is 0.
- R7: If `vpa_i` alone ends the cycle, `vector_o` becomes 0x18 plus the level, with the same timing as R6.
- R8: If `dtack_i` and `vpa_i` are sampled together, the cycle ends as in R6, but `err_o` is 1 during the `done_o` cycle and `vector_o` is 0x18.
- R9: While neither termination is sampled, the strobes stay 1 for any number of cycles.
- R10: `start_i` and `level_i` are ignored while busy, and the level on the address does not change.
- R11: A termination seen during the address-setup cycle is ignored and does not end the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to acknowledge `level_i` |
| level_i | input | 3 | Interrupt level to acknowledge |
| busy_o | output | 1 | Acknowledge cycle in progress |
| fc_o | output | 3 | Function code (111 while busy) |
| addr_o | output | ADDR_W | Cycle address |
| rw_o | output | 1 | Read/write, 1 = read |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| data_i | input | DATA_W | Data bus input |
| dtack_i | input | 1 | Data acknowledge termination |
| vpa_i | input | 1 | Peripheral-valid (autovector) termination |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Both terminations seen, valid with `done_o` |
| vector_o | output | VEC_W | Vector number, held until the next completion |

## Verification
A wrong phase shows up at the ports within one cycle. It appears as strobes that rise with the address instead of one cycle later, as strobes that drop without a termination, or as a `done_o` that lasts two cycles. A wrongly latched level appears at once on `addr_o[3:1]`, and again one cycle after a peripheral-valid termination, as a wrong autovector. A wrong selection between the device byte, the autovector and the spurious vector becomes visible on `vector_o` in the cycle after termination. It stays visible there until the next acknowledge completes.

// File: rtl/iack_pkg.sv
package iack_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } iack_phase_e;

    localparam logic [2:0] FC_CPU_SPACE = 3'b111;
    localparam logic [2:0] FC_NONE      = 3'b000;
endpackage

// File: rtl/iack_addr_gen.sv
module iack_addr_gen
    import iack_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              busy,
    input  logic [2:0]        level,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        fc
);
    always_comb begin
        addr = '0;
        fc   = FC_NONE;
        if (busy) begin
            addr      = '1;
            addr[3:1] = level;
            fc        = FC_CPU_SPACE;
        end
    end
endmodule

// File: rtl/iack_vec_sel.sv
module iack_vec_sel #(
    parameter int              VEC_W     = 8,
    parameter int              DATA_W    = 16,
    parameter logic [VEC_W-1:0] AUTO_BASE = 8'h18,
    parameter logic [VEC_W-1:0] SPUR_VEC  = 8'h18
) (
    input  logic [2:0]        level,
    input  logic [DATA_W-1:0] data,
    input  logic              dtack,
    input  logic              vpa,
    output logic              term,
    output logic              clash,
    output logic [VEC_W-1:0]  vector
);
    localparam int PAD_W = VEC_W - 3;

    logic [VEC_W-1:0] auto_vec;

    assign auto_vec = AUTO_BASE + {{PAD_W{1'b0}}, level};
    assign term     = dtack | vpa;
    assign clash    = dtack & vpa;

    always_comb begin
        if (clash)      vector = SPUR_VEC;
        else if (dtack) vector = data[VEC_W-1:0];
        else            vector = auto_vec;
    end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 16,
    parameter int              VEC_W     = 8,
    parameter logic [VEC_W-1:0] AUTO_BASE = 8'h18,
    parameter logic [VEC_W-1:0] SPUR_VEC  = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        level_i,
    output logic              busy_o,
    output logic [2:0]        fc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    output logic              as_o,
    output logic              ds_o,
    input  logic [DATA_W-1:0] data_i,
    input  logic              dtack_i,
    input  logic              vpa_i,
    output logic              done_o,
    output logic              err_o,
    output logic [VEC_W-1:0]  vector_o
);
    typedef struct packed {
        iack_phase_e      phase;
        logic [2:0]       level;
        logic [VEC_W-1:0] vector;
        logic             err;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             term_w, clash_w;
    logic [VEC_W-1:0] vec_w;
    logic             strobe_w;

    iack_vec_sel #(
        .VEC_W    (VEC_W),
        .DATA_W   (DATA_W),
        .AUTO_BASE(AUTO_BASE),
        .SPUR_VEC (SPUR_VEC)
    ) u_vec (
        .level (st_q.level),
        .data  (data_i),
        .dtack (dtack_i),
        .vpa   (vpa_i),
        .term  (term_w),
        .clash (clash_w),
        .vector(vec_w)
    );

    iack_addr_gen #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .busy (busy_o),
        .level(st_q.level),
        .addr (addr_o),
        .fc   (fc_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i && (level_i != 3'd0)) begin
                    st_d.level = level_i;
                    st_d.phase = PH_ADDR;
                end
            end
            PH_ADDR: st_d.phase = PH_WAIT;
            PH_WAIT: begin
                if (term_w) begin
                    st_d.vector = vec_w;
                    st_d.err    = clash_w;
                    st_d.done   = 1'b1;
                    st_d.phase  = PH_DONE;
                end
            end
            PH_DONE: st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.level  <= 3'd0;
            st_q.vector <= '0;
            st_q.err    <= 1'b0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_w = (st_q.phase == PH_WAIT);
    assign busy_o   = (st_q.phase == PH_ADDR) || strobe_w;
    assign as_o     = strobe_w;
    assign ds_o     = strobe_w;
    assign rw_o     = 1'b1;
    assign done_o   = st_q.done;
    assign err_o    = st_q.err;
    assign vector_o = st_q.vector;
endmodule

// File: rtl/iack_seq_chk.sv
module iack_seq_chk #(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 16,
    parameter int              VEC_W     = 8,
    parameter logic [VEC_W-1:0] AUTO_BASE = 8'h18,
    parameter logic [VEC_W-1:0] SPUR_VEC  = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        level_i,
    input logic              busy_o,
    input logic [2:0]        fc_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              rw_o,
    input logic              as_o,
    input logic              ds_o,
    input logic [DATA_W-1:0] data_i,
    input logic              dtack_i,
    input logic              vpa_i,
    input logic              done_o,
    input logic              err_o,
    input logic [VEC_W-1:0]  vector_o
);
    logic [2:0]       lvl_prev;
    logic [VEC_W-1:0] byte_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev  <= 3'd0;
            byte_prev <= '0;
        end else begin
            lvl_prev  <= addr_o[3:1];
            byte_prev <= data_i[VEC_W-1:0];
        end
    end

    AST_FC_CPU_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (fc_o == 3'b111 && rw_o)); // R2
    AST_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (addr_o[0] && (&addr_o[ADDR_W-1:4]))); // R3
    AST_DS_WITH_AS: assert property (@(posedge clk) disable iff (!rst_n)
        ds_o |-> (as_o && busy_o)); // R4
    AST_LEVEL0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && start_i && level_i == 3'd0) |=> !busy_o); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DTACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && dtack_i && !vpa_i) |=> (done_o && !err_o && vector_o == byte_prev)); // R6
    AST_AUTOVECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && vpa_i && !dtack_i) |=> (done_o && vector_o == AUTO_BASE + {{(VEC_W-3){1'b0}}, lvl_prev})); // R7
    AST_CLASH_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && dtack_i && vpa_i) |=> (done_o && err_o && vector_o == SPUR_VEC)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R8
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && !dtack_i && !vpa_i) |=> as_o); // R9
    AST_LEVEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(addr_o)); // R10
    AST_SETUP_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !as_o) |=> (as_o && !done_o)); // R11
endmodule

bind iack_seq iack_seq_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_W    (VEC_W),
    .AUTO_BASE(AUTO_BASE),
    .SPUR_VEC (SPUR_VEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .level_i (level_i),
    .busy_o  (busy_o),
    .fc_o    (fc_o),
    .addr_o  (addr_o),
    .rw_o    (rw_o),
    .as_o    (as_o),
    .ds_o    (ds_o),
    .data_i  (data_i),
    .dtack_i (dtack_i),
    .vpa_i   (vpa_i),
    .done_o  (done_o),
    .err_o   (err_o),
    .vector_o(vector_o)
);

// File: tb/tb_iack_seq.sv
`timescale 1ns/1ps
module tb_iack_seq;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int VEC_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        level_i = 3'd0;
    logic              busy_o;
    logic [2:0]        fc_o;
    logic [ADDR_W-1:0] addr_o;
    logic              rw_o, as_o, ds_o;
    logic [DATA_W-1:0] data_i = '0;
    logic              dtack_i = 1'b0;
    logic              vpa_i = 1'b0;
    logic              done_o, err_o;
    logic [VEC_W-1:0]  vector_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    iack_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .busy_o(busy_o), .fc_o(fc_o), .addr_o(addr_o), .rw_o(rw_o),
        .as_o(as_o), .ds_o(ds_o), .data_i(data_i), .dtack_i(dtack_i),
        .vpa_i(vpa_i), .done_o(done_o), .err_o(err_o), .vector_o(vector_o)
    );

    // Behavioural reference: step 0 idle, 1 setup, 2 strobing, 3 completion
    int       m_step = 0;
    int       m_lvl = 0;
    int       m_vec = 0;
    bit       m_err = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step <= 0; m_lvl <= 0; m_vec <= 0; m_err <= 1'b0;
        end else begin
            m_err <= 1'b0;
            case (m_step)
                0: if (start_i && level_i != 0) begin m_lvl <= int'(level_i); m_step <= 1; end
                1: m_step <= 2;
                2: if (dtack_i || vpa_i) begin
                       m_step <= 3;
                       if (dtack_i && vpa_i) begin m_vec <= 'h18; m_err <= 1'b1; end
                       else if (dtack_i) m_vec <= int'(data_i[7:0]);
                       else m_vec <= 'h18 + m_lvl;
                   end
                default: m_step <= 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input int step, input int lvl);
        logic [ADDR_W-1:0] a;
        a = '0;
        if (step == 1 || step == 2) begin
            a = '1;
            a[3:1] = lvl[2:0];
        end
        return a;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bsy;
            bsy = (m_step == 1 || m_step == 2);
            check(busy_o == bsy && fc_o == (bsy ? 3'b111 : 3'b000) && rw_o,
                  "R2", "busy/fc/rw", {busy_o, fc_o, rw_o}, {bsy, bsy ? 3'b111 : 3'b000, 1'b1});
            check(addr_o == exp_addr(m_step, m_lvl), "R3", "addr",
                  addr_o, exp_addr(m_step, m_lvl));
            check(as_o == (m_step == 2) && ds_o == (m_step == 2), "R4", "strobes",
                  {as_o, ds_o}, {(m_step == 2), (m_step == 2)});
            check(done_o == (m_step == 3), "R6", "done", done_o, (m_step == 3));
            check(err_o == m_err, "R8", "err", err_o, m_err);
            check(int'(vector_o) == m_vec, "R7", "vector", vector_o, m_vec);
        end
    end

    task automatic ack(input int lvl, input int waits, input bit dt, input bit vp,
                       input logic [15:0] dat, input bit early, input bit restart,
                       input int exp_vec, input bit exp_err, input string tag);
        @(negedge clk);
        start_i = 1'b1; level_i = lvl[2:0];
        @(negedge clk);
        if (restart) level_i = 3'(lvl + 1);
        else begin start_i = 1'b0; level_i = 3'd0; end
        if (early) dtack_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; level_i = 3'd0;
        if (early) begin
            dtack_i = 1'b0;
            check(as_o && !done_o, "R11", "early term ignored", {as_o, done_o}, 2'b10);
        end
        if (restart)
            check(addr_o[3:1] == lvl[2:0], "R10", "level kept", addr_o[3:1], lvl);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check(as_o && ds_o, "R9", "wait state strobes", {as_o, ds_o}, 2'b11);
        end
        data_i = dat; dtack_i = dt; vpa_i = vp;
        @(negedge clk);
        dtack_i = 1'b0; vpa_i = 1'b0; data_i = '0;
        check(done_o && !busy_o, tag, "completion", {done_o, busy_o}, 2'b10);
        check(int'(vector_o) == exp_vec && err_o == exp_err, tag, "result",
              {err_o, vector_o}, {exp_err, exp_vec[7:0]});
        @(negedge clk);
        check(!done_o && !err_o, "R6", "single pulse", {done_o, err_o}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !as_o && !ds_o && !done_o && !err_o && fc_o == 3'b000 &&
              addr_o == '0 && vector_o == '0 && rw_o, "R1", "reset state",
              {busy_o, as_o, ds_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ack(5, 3, 1'b1, 1'b0, 16'hA7C3, 1'b0, 1'b0, 'hC3, 1'b0, "R6");
        ack(3, 0, 1'b0, 1'b1, 16'h5555, 1'b0, 1'b0, 'h1B, 1'b0, "R7");
        ack(7, 1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 'h1F, 1'b0, "R7");
        ack(1, 2, 1'b1, 1'b1, 16'h00EE, 1'b0, 1'b0, 'h18, 1'b1, "R8");
        ack(2, 5, 1'b1, 1'b0, 16'h1240, 1'b0, 1'b1, 'h40, 1'b0, "R6");
        @(negedge clk);
        start_i = 1'b1; level_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        check(!busy_o && addr_o == '0, "R5", "level 0 ignored", busy_o, 0);
        @(negedge clk);
        check(!busy_o && int'(vector_o) == 'h40, "R5", "vector unchanged", vector_o, 'h40);
        ack(6, 40, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 'h1E, 1'b0, "R7");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule